// File: doc/BRIEF.md
# Two-Master Locked Exchange Arbiter

This block lets two bus masters share one small word-addressed store that holds semaphore words. Each master presents a request with a direction select, an address, write data and a lock flag. The arbiter picks at most one request per clock and performs the access on that clock's edge. In the following cycle it raises that master's ready pulse, and the read data bus carries the word the location held before the access.

An atomic exchange is built from a read followed by a write to the same word. If the read is issued with lock set, the arbiter binds the bus to that master. The other master is held off until the owner's next write completes, so no third access can fall between the two halves. If lock is clear, the other master may take the cycle between the read and the write. In that case two masters can both see a free semaphore and both enter their critical sections.

The semaphore convention is that 1 means free. A master claims the word by exchanging 0 into it. Reading back 0 means the claim failed and the master must retry. A master releases the word with an ordinary write of 1.

Top module: `xchg_arbiter`

## Requirements
- R1: After reset neither ready output is high, and every memory word reads back as 1 (free).
- R2: A granted request completes with a ready pulse one cycle wide, in the cycle after the grant. A write stores its data at the addressed word.
- R3: The read data presented with ready is the value the word held before that access. This holds for reads and for writes.
- R4: At most one master is granted on any clock.
- R5: When both masters are eligible on the same clock, the grant goes to the master that was not granted most recently. After reset, master 0 wins first.
- R6: A master is never granted in a cycle in which its own ready is high. A lone master therefore completes back-to-back transfers two cycles apart, while a different master can complete one cycle after the previous ready.
- R7: A read issued with lock set makes its master the owner. The other master gets no grant until the owner's next write has been granted.
- R8: With lock clear, two exchanges on the same semaphore can interleave as read A, read B, write A, write B, and both masters then read 1.
- R9: With lock set on both exchanges, exactly one master reads 1 and the other reads 0. After the winner releases the word by writing 1, the loser's retried exchange reads 1.
- R10: Lock set on a write request has no effect. The other master is served without delay afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m0_req | input | 1 | Master 0 request, held until its ready |
| m0_lock | input | 1 | Master 0 lock flag for an exchange |
| m0_we | input | 1 | Master 0 direction, 1 = write |
| m0_addr | input | AW | Master 0 word address |
| m0_wdata | input | DW | Master 0 write data |
| m0_ready | output | 1 | Master 0 transfer-complete pulse |
| m0_rdata | output | DW | Prior word value, valid with m0_ready |
| m1_req | input | 1 | Master 1 request, held until its ready |
| m1_lock | input | 1 | Master 1 lock flag for an exchange |
| m1_we | input | 1 | Master 1 direction, 1 = write |
| m1_addr | input | AW | Master 1 word address |
| m1_wdata | input | DW | Master 1 write data |
| m1_ready | output | 1 | Master 1 transfer-complete pulse |
| m1_rdata | output | DW | Prior word value, valid with m1_ready |

## Verification
The assertions check four properties on every clock:
- the grant is one-hot or idle;
- while the bus is bound, no grant goes to the non-owner;
- a ready pulse never lasts two cycles;
- a granted write lands in the addressed word.

Other behaviours only show up in the bench's multi-cycle scenarios. These are the round-robin choice between simultaneous requests, the interleaved unlocked race in which both masters read 1, and the locked race with its stall, failed claim, release and successful retry. The zero effect of lock on a write is also shown that way.

// File: rtl/xarb_pkg.sv
package xarb_pkg;

    typedef struct packed {
        logic [1:0] rdy;    // per-master completion pulse
        logic       last;   // master granted most recently
        logic       held;   // bus bound to owner
        logic       owner;  // master holding the bus
    } gstate_t;

    localparam gstate_t GSTATE_RST = '{rdy: 2'b00, last: 1'b1, held: 1'b0, owner: 1'b0};

endpackage

// File: rtl/xarb_grant.sv
module xarb_grant
    import xarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic [1:0] lock,
    input  logic [1:0] we,
    output logic [1:0] gnt,
    output logic [1:0] ready
);

    gstate_t    s_q, s_d;
    logic [1:0] elig;
    logic       idx;

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            elig[i] = req[i] & ~s_q.rdy[i] & (~s_q.held | (s_q.owner == 1'(i)));
        end
        if (elig == 2'b11) begin
            gnt = s_q.last ? 2'b01 : 2'b10;
        end else begin
            gnt = elig;
        end
        idx       = gnt[1];
        s_d       = s_q;
        s_d.rdy   = gnt;
        if (|gnt) begin
            s_d.last = idx;
            if (lock[idx] && !we[idx]) begin
                s_d.held  = 1'b1;
                s_d.owner = idx;
            end else if (s_q.held && we[idx]) begin
                s_d.held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= GSTATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = s_q.rdy;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R4

    AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.held |-> !gnt[~s_q.owner]); // R7

    AST_READY_GAP_M0: assert property (@(posedge clk) disable iff (!rst_n)
        ready[0] |=> !ready[0]); // R6

    AST_READY_GAP_M1: assert property (@(posedge clk) disable iff (!rst_n)
        ready[1] |=> !ready[1]); // R6

endmodule

// File: rtl/xarb_mem.sv
module xarb_mem #(
    parameter int AW      = 3,
    parameter int DW      = 8,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words_q [DEPTH];
    logic [DW-1:0] words_d [DEPTH];
    logic [DW-1:0] rdata_q, rdata_d;

    always_comb begin
        words_d = words_q;
        rdata_d = rdata_q;
        if (en) begin
            rdata_d = words_q[addr];
            if (we) begin
                words_d[addr] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words_q[i] <= DW'(RST_VAL);
            end
            rdata_q <= '0;
        end else begin
            words_q <= words_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (words_q[$past(addr)] == $past(wdata))); // R2

endmodule

// File: rtl/xchg_arbiter.sv
module xchg_arbiter #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m0_req,
    input  logic          m0_lock,
    input  logic          m0_we,
    input  logic [AW-1:0] m0_addr,
    input  logic [DW-1:0] m0_wdata,
    output logic          m0_ready,
    output logic [DW-1:0] m0_rdata,
    input  logic          m1_req,
    input  logic          m1_lock,
    input  logic          m1_we,
    input  logic [AW-1:0] m1_addr,
    input  logic [DW-1:0] m1_wdata,
    output logic          m1_ready,
    output logic [DW-1:0] m1_rdata
);

    logic [1:0]    gnt;
    logic [1:0]    rdy;
    logic          sel_we;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic [DW-1:0] mem_rdata;

    xarb_grant u_grant (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({m1_req,  m0_req}),
        .lock  ({m1_lock, m0_lock}),
        .we    ({m1_we,   m0_we}),
        .gnt   (gnt),
        .ready (rdy)
    );

    always_comb begin
        if (gnt[1]) begin
            sel_we    = m1_we;
            sel_addr  = m1_addr;
            sel_wdata = m1_wdata;
        end else begin
            sel_we    = m0_we;
            sel_addr  = m0_addr;
            sel_wdata = m0_wdata;
        end
    end

    xarb_mem #(.AW(AW), .DW(DW), .RST_VAL(1)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (|gnt),
        .we    (sel_we),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (mem_rdata)
    );

    assign m0_ready = rdy[0];
    assign m1_ready = rdy[1];
    assign m0_rdata = mem_rdata;
    assign m1_rdata = mem_rdata;

endmodule

// File: tb/tb_xchg_arbiter.sv
`timescale 1ns/1ps
module tb_xchg_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = '0, lk = '0, we = '0;
    logic [2:0] addr [2];
    logic [7:0] wd [2];
    wire  [1:0] rdy;
    wire  [7:0] rdt [2];
    int nchk = 0, nfail = 0, cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xchg_arbiter #(.AW(3), .DW(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .m0_req(req[0]), .m0_lock(lk[0]), .m0_we(we[0]), .m0_addr(addr[0]),
        .m0_wdata(wd[0]), .m0_ready(rdy[0]), .m0_rdata(rdt[0]),
        .m1_req(req[1]), .m1_lock(lk[1]), .m1_we(we[1]), .m1_addr(addr[1]),
        .m1_wdata(wd[1]), .m1_ready(rdy[1]), .m1_rdata(rdt[1])
    );

    typedef struct packed {
        logic       m;
        logic       l;
        logic       w;
        logic [2:0] a;
        logic [7:0] d;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{m:1'b0, l:1'b0, w:1'b0, a:3'd2, d:8'h00, exp:8'h01},
        '{m:1'b1, l:1'b0, w:1'b1, a:3'd2, d:8'h5A, exp:8'h01},
        '{m:1'b0, l:1'b0, w:1'b0, a:3'd2, d:8'h00, exp:8'h5A},
        '{m:1'b0, l:1'b1, w:1'b1, a:3'd5, d:8'hC3, exp:8'h01},
        '{m:1'b1, l:1'b0, w:1'b0, a:3'd5, d:8'h00, exp:8'hC3},
        '{m:1'b1, l:1'b0, w:1'b1, a:3'd2, d:8'hFF, exp:8'h5A},
        '{m:1'b0, l:1'b0, w:1'b0, a:3'd2, d:8'h00, exp:8'hFF},
        '{m:1'b1, l:1'b0, w:1'b0, a:3'd5, d:8'h00, exp:8'hC3}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns prior data, wait count and stamp.
    task automatic xfer(input int m, input bit l, input bit w, input logic [2:0] a,
                        input logic [7:0] d, output logic [7:0] rd,
                        output int n, output int stamp);
        req[m] = 1'b1; lk[m] = l; we[m] = w; addr[m] = a; wd[m] = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rdy[m] && n < 30);
        if (!rdy[m]) check(1'b0, "ready timeout", n, 0);
        rd = rdt[m];
        stamp = cyc;
        req[m] = 1'b0; lk[m] = 1'b0;
    endtask

    task automatic xchg(input int m, input bit l, input logic [2:0] a,
                        output logic [7:0] old, output int rs, output int ws);
        logic [7:0] dummy;
        int n;
        xfer(m, l, 1'b0, a, 8'h00, old, n, rs);
        xfer(m, l, 1'b1, a, 8'h00, dummy, n, ws);
    endtask

    initial begin
        #2000000;
        check(1'b0, "watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] rd, o0, o1;
        int n, s0, s1, w0, w1, prev;
        addr[0] = '0; addr[1] = '0; wd[0] = '0; wd[1] = '0;
        repeat (3) @(negedge clk);
        check(rdy == 2'b00, "R1 ready idle in reset", rdy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy == 2'b00, "R1 ready idle after reset", rdy, 0);

        // R1: every word free after reset
        for (int a = 0; a < 8; a++) begin
            xfer(0, 1'b0, 1'b0, 3'(a), 8'h00, rd, n, s0);
            check(rd == 8'h01, "R1 reset word", rd, 1);
        end
        @(negedge clk);

        // Table walk: R2 data and latency, R3 prior value, R6 spacing, R10 lock on write
        prev = -1;
        for (int i = 0; i < NV; i++) begin
            int explat;
            string tag;
            explat = (prev == int'(VEC[i].m)) ? 2 : 1;
            tag = (i > 0 && VEC[i-1].l && VEC[i-1].w) ? "R10 latency"
                : (explat == 2) ? "R6 latency" : "R2 latency";
            xfer(int'(VEC[i].m), VEC[i].l, VEC[i].w, VEC[i].a, VEC[i].d, rd, n, s0);
            check(rd == VEC[i].exp, "R3 prior value", rd, VEC[i].exp);
            check(n == explat, tag, n, explat);
            prev = int'(VEC[i].m);
        end
        @(negedge clk);
        check(rdy == 2'b00, "R2 ready one cycle wide", rdy, 0);

        // R5: round robin after master 1 alone, then after master 0 alone
        xfer(1, 1'b0, 1'b0, 3'd0, 8'h00, rd, n, s0);
        @(negedge clk);
        fork
            xfer(0, 1'b0, 1'b0, 3'd0, 8'h00, o0, n, s0);
            xfer(1, 1'b0, 1'b0, 3'd0, 8'h00, o1, n, s1);
        join
        check(s0 < s1, "R5 master 0 wins after master 1", s0, s1);
        @(negedge clk);
        xfer(0, 1'b0, 1'b0, 3'd0, 8'h00, rd, n, s0);
        @(negedge clk);
        fork
            xfer(0, 1'b0, 1'b0, 3'd0, 8'h00, o0, n, s0);
            xfer(1, 1'b0, 1'b0, 3'd0, 8'h00, o1, n, s1);
        join
        check(s1 < s0, "R5 master 1 wins after master 0", s1, s0);
        @(negedge clk);

        // R8: unlocked race, both claim
        xfer(0, 1'b0, 1'b1, 3'd0, 8'h01, rd, n, s0);
        @(negedge clk);
        fork
            xchg(0, 1'b0, 3'd0, o0, s0, w0);
            xchg(1, 1'b0, 3'd0, o1, s1, w1);
        join
        check(o0 == 8'h01, "R8 master 0 saw free", o0, 1);
        check(o1 == 8'h01, "R8 master 1 saw free", o1, 1);
        @(negedge clk);

        // R7 and R9: locked race
        xfer(0, 1'b0, 1'b1, 3'd1, 8'h01, rd, n, s0);
        @(negedge clk);
        fork
            xchg(0, 1'b1, 3'd1, o0, s0, w0);
            xchg(1, 1'b1, 3'd1, o1, s1, w1);
        join
        check((o0 ^ o1) == 8'h01, "R9 exactly one claim", o0 ^ o1, 1);
        if (o0 == 8'h01) begin
            check(s1 > w0, "R7 loser stalled until owner write", s1, w0);
            xfer(0, 1'b0, 1'b1, 3'd1, 8'h01, rd, n, s0);
            xchg(1, 1'b1, 3'd1, o1, s1, w1);
            check(o1 == 8'h01, "R9 retry after release", o1, 1);
        end else begin
            check(s0 > w1, "R7 loser stalled until owner write", s0, w1);
            xfer(1, 1'b0, 1'b1, 3'd1, 8'h01, rd, n, s1);
            xchg(0, 1'b1, 3'd1, o0, s0, w0);
            check(o0 == 8'h01, "R9 retry after release", o0, 1);
        end
        xfer(0, 1'b0, 1'b0, 3'd1, 8'h00, rd, n, s0);
        check(rd == 8'h00, "R9 word claimed after retry", rd, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule